// File: doc/BRIEF.md
# Pipeline Hazard and Flush Controller

This block is the hazard control unit for a five-stage in-order pipeline with a single architectural branch delay slot. It looks at the register fields and instruction classes of the instructions in the decode, execute and memory stages, and at the destination of the instruction in write-back. From these it decides when the front of the pipeline must freeze, when a freshly fetched instruction must be discarded, and where each operand should come from. The block is purely combinational. All of its outputs are recomputed from the current stage contents in every cycle, and none of them is held in a pipeline register.

Conditional branches compare their operands and resolve in decode, so the only instruction fetched behind them is the delay slot, which always executes. A register-indirect jump resolves in execute. At that point its delay slot already sits in decode, so the instruction being fetched at the same time is squashed. A branch in decode that needs a value the execute stage is still producing waits one bubble. A branch waiting on a load waits until the load data reaches write-back. A non-branch consumer of a load waits one bubble. Every other dependency is served by the forwarding selects, which feed both the ALU inputs in execute and the branch comparator in decode.

Top module: `pipe_hazard_ctrl`

## Requirements
- R1: When the execute stage holds a load (ex_load=1, ex_wen=1) with a nonzero destination equal to a decode source register that is in use (id_rs with id_use_rs=1, or id_rt with id_use_rt=1), id_stall is 1.
- R2: When decode holds a conditional branch (id_branch=1) and any in-use source register equals a nonzero destination being written by the execute stage (ex_wen=1), id_stall is 1, whether or not that instruction is a load.
- R3: When decode holds a conditional branch and a load in the memory stage (mem_load=1, mem_wen=1) writes a nonzero register that the branch reads, id_stall is 1. Together with R2, a branch that directly follows a load stalls for exactly two cycles.
- R4: In every case not covered by R1 to R3, id_stall is 0. This includes a non-branch consumer of a non-load result in execute, and every dependency on a value in memory or write-back that is not covered by R3.
- R5: if_squash is 1 exactly when the execute stage holds a register jump (ex_jr=1) and id_stall is 0. It is never 1 together with id_stall.
- R6: pc_hold equals id_stall, except that it is 0 whenever ex_jr=1, so the jump redirect is never blocked by a stall.
- R7: Each forwarding select uses the encoding 2'b00 = register file, 2'b01 = write-back value, 2'b10 = memory-stage ALU result. The value 2'b11 is never produced.
- R8: A select is 2'b10 when the memory stage writes (mem_wen=1), is not a load (mem_load=0), and its destination equals the operand register. This case has priority over a write-back match (wb_wen=1, wb_dst equal), which gives 2'b01.
- R9: Register zero is never forwarded and never causes a stall.
- R10: The branch comparator selects (cmp_a_sel for id_rs, cmp_b_sel for id_rt) follow R7 to R9. So do the ALU selects (alu_a_sel for ex_rs, alu_b_sel for ex_rt), which also carry the target of a register jump in execute. This lets a link register written by a preceding jump-and-link be picked up from the memory stage.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| id_rs | input | 5 | First source register of the decode instruction |
| id_rt | input | 5 | Second source register of the decode instruction |
| id_use_rs | input | 1 | Decode instruction reads id_rs |
| id_use_rt | input | 1 | Decode instruction reads id_rt |
| id_branch | input | 1 | Decode instruction is a conditional branch |
| ex_rs | input | 5 | First source register of the execute instruction |
| ex_rt | input | 5 | Second source register of the execute instruction |
| ex_dst | input | 5 | Destination register of the execute instruction |
| ex_wen | input | 1 | Execute instruction writes a register |
| ex_load | input | 1 | Execute instruction is a load |
| ex_jr | input | 1 | Execute instruction is a register jump |
| mem_dst | input | 5 | Destination register of the memory-stage instruction |
| mem_wen | input | 1 | Memory-stage instruction writes a register |
| mem_load | input | 1 | Memory-stage instruction is a load |
| wb_dst | input | 5 | Destination register of the write-back instruction |
| wb_wen | input | 1 | Write-back instruction writes a register |
| pc_hold | output | 1 | Keep the program counter unchanged |
| id_stall | output | 1 | Hold the fetch/decode register and put a bubble into decode/execute |
| if_squash | output | 1 | Load a NOP into the fetch/decode register instead of the fetched word |
| alu_a_sel | output | 2 | Source select for ALU operand A (ex_rs) |
| alu_b_sel | output | 2 | Source select for ALU operand B (ex_rt) |
| cmp_a_sel | output | 2 | Source select for branch compare operand A (id_rs) |
| cmp_b_sel | output | 2 | Source select for branch compare operand B (id_rt) |

## Verification
The hardest situation to reach is a register jump in execute while decode is stalled by a branch that waits on a load in the memory stage. Here the stall and the jump redirect pull in opposite directions, and random stage contents rarely line up the load, the branch and the jump at once. The stimulus draws register numbers from a four-entry range so that matches are frequent, and it sets the class flags at random. On top of this, directed steps replay the load-then-branch sequence cycle by cycle, place a jump-and-link in the memory stage ahead of a register jump, and force the stall-plus-jump collision explicitly.

// File: rtl/hzd_pkg.sv
package hzd_pkg;

  // Operand source codes shared by the forwarding pickers and the top level.
  typedef enum logic [1:0] {
    SRC_REGF = 2'b00,
    SRC_WBK  = 2'b01,
    SRC_MEMR = 2'b10
  } opnd_src_e;

  localparam int unsigned NUM_PICKS = 4;

endpackage

// File: rtl/hzd_fwd_pick.sv
module hzd_fwd_pick
  import hzd_pkg::*;
#(
  parameter int unsigned REG_W = 5
) (
  input  logic [REG_W-1:0] opnd_reg,
  input  logic [REG_W-1:0] mem_dst,
  input  logic             mem_wen,
  input  logic             mem_load,
  input  logic [REG_W-1:0] wb_dst,
  input  logic             wb_wen,
  output opnd_src_e        src_sel
);

  logic live_reg;
  logic hit_mem;
  logic hit_wbk;

  always_comb begin
    live_reg = (opnd_reg != '0);
    hit_mem  = live_reg && mem_wen && !mem_load && (mem_dst == opnd_reg);
    hit_wbk  = live_reg && wb_wen && (wb_dst == opnd_reg);
    if (hit_mem) begin
      src_sel = SRC_MEMR;
    end else if (hit_wbk) begin
      src_sel = SRC_WBK;
    end else begin
      src_sel = SRC_REGF;
    end
    // R7
    sel_code_chk: assert (src_sel != 2'b11)
      else $error("forward select produced reserved code");
    // R9
    zero_reg_chk: assert (live_reg || src_sel == SRC_REGF)
      else $error("register zero forwarded");
    // R8
    mem_prio_chk: assert (!(hit_mem && hit_wbk) || src_sel == SRC_MEMR)
      else $error("memory stage lost priority to write-back");
  end

endmodule

// File: rtl/hzd_stall_gen.sv
module hzd_stall_gen #(
  parameter int unsigned REG_W = 5
) (
  input  logic [REG_W-1:0] id_rs,
  input  logic [REG_W-1:0] id_rt,
  input  logic             id_use_rs,
  input  logic             id_use_rt,
  input  logic             id_branch,
  input  logic [REG_W-1:0] ex_dst,
  input  logic             ex_wen,
  input  logic             ex_load,
  input  logic [REG_W-1:0] mem_dst,
  input  logic             mem_wen,
  input  logic             mem_load,
  output logic             stall
);

  logic ex_reads;
  logic mem_reads;
  logic load_use;
  logic br_on_ex;
  logic br_on_mload;

  always_comb begin
    ex_reads  = (ex_dst != '0) && ex_wen &&
                ((id_use_rs && id_rs == ex_dst) || (id_use_rt && id_rt == ex_dst));
    mem_reads = (mem_dst != '0) && mem_wen &&
                ((id_use_rs && id_rs == mem_dst) || (id_use_rt && id_rt == mem_dst));
    load_use    = ex_reads && ex_load;
    br_on_ex    = ex_reads && id_branch;
    br_on_mload = mem_reads && mem_load && id_branch;
    stall       = load_use || br_on_ex || br_on_mload;
    // R9
    zero_stall_chk: assert (!(stall && ex_dst == '0 && mem_dst == '0))
      else $error("stall raised by register zero");
    // R4
    no_alu_stall_chk: assert (id_branch || !stall || ex_load)
      else $error("non-branch stalled on a non-load");
  end

endmodule

// File: rtl/pipe_hazard_ctrl.sv
module pipe_hazard_ctrl
  import hzd_pkg::*;
#(
  parameter int unsigned REG_W = 5
) (
  input  logic [REG_W-1:0] id_rs,
  input  logic [REG_W-1:0] id_rt,
  input  logic             id_use_rs,
  input  logic             id_use_rt,
  input  logic             id_branch,
  input  logic [REG_W-1:0] ex_rs,
  input  logic [REG_W-1:0] ex_rt,
  input  logic [REG_W-1:0] ex_dst,
  input  logic             ex_wen,
  input  logic             ex_load,
  input  logic             ex_jr,
  input  logic [REG_W-1:0] mem_dst,
  input  logic             mem_wen,
  input  logic             mem_load,
  input  logic [REG_W-1:0] wb_dst,
  input  logic             wb_wen,
  output logic             pc_hold,
  output logic             id_stall,
  output logic             if_squash,
  output logic [1:0]       alu_a_sel,
  output logic [1:0]       alu_b_sel,
  output logic [1:0]       cmp_a_sel,
  output logic [1:0]       cmp_b_sel
);

  logic [REG_W-1:0] pick_reg [NUM_PICKS];
  opnd_src_e        pick_sel [NUM_PICKS];
  logic             stall_w;

  assign pick_reg[0] = id_rs;
  assign pick_reg[1] = id_rt;
  assign pick_reg[2] = ex_rs;
  assign pick_reg[3] = ex_rt;

  for (genvar g = 0; g < NUM_PICKS; g++) begin : g_pick
    hzd_fwd_pick #(.REG_W(REG_W)) u_pick (
      .opnd_reg (pick_reg[g]),
      .mem_dst  (mem_dst),
      .mem_wen  (mem_wen),
      .mem_load (mem_load),
      .wb_dst   (wb_dst),
      .wb_wen   (wb_wen),
      .src_sel  (pick_sel[g])
    );
  end

  hzd_stall_gen #(.REG_W(REG_W)) u_stall (
    .id_rs     (id_rs),
    .id_rt     (id_rt),
    .id_use_rs (id_use_rs),
    .id_use_rt (id_use_rt),
    .id_branch (id_branch),
    .ex_dst    (ex_dst),
    .ex_wen    (ex_wen),
    .ex_load   (ex_load),
    .mem_dst   (mem_dst),
    .mem_wen   (mem_wen),
    .mem_load  (mem_load),
    .stall     (stall_w)
  );

  always_comb begin
    id_stall  = stall_w;
    if_squash = ex_jr && !stall_w;
    pc_hold   = stall_w && !ex_jr;
    cmp_a_sel = pick_sel[0];
    cmp_b_sel = pick_sel[1];
    alu_a_sel = pick_sel[2];
    alu_b_sel = pick_sel[3];
    // R5
    squash_excl_chk: assert (!(if_squash && id_stall))
      else $error("squash together with stall");
    // R6
    redirect_chk: assert (!(ex_jr && pc_hold))
      else $error("program counter held during jump redirect");
  end

endmodule

// File: tb/pipe_hazard_ctrl_test.sv
module pipe_hazard_ctrl_test;

  localparam int RW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [RW-1:0] id_rs, id_rt, ex_rs, ex_rt, ex_dst, mem_dst, wb_dst;
  logic id_use_rs, id_use_rt, id_branch, ex_wen, ex_load, ex_jr;
  logic mem_wen, mem_load, wb_wen;
  logic pc_hold, id_stall, if_squash;
  logic [1:0] alu_a_sel, alu_b_sel, cmp_a_sel, cmp_b_sel;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  pipe_hazard_ctrl #(.REG_W(RW)) uut (
    .id_rs(id_rs), .id_rt(id_rt), .id_use_rs(id_use_rs), .id_use_rt(id_use_rt),
    .id_branch(id_branch), .ex_rs(ex_rs), .ex_rt(ex_rt), .ex_dst(ex_dst),
    .ex_wen(ex_wen), .ex_load(ex_load), .ex_jr(ex_jr), .mem_dst(mem_dst),
    .mem_wen(mem_wen), .mem_load(mem_load), .wb_dst(wb_dst), .wb_wen(wb_wen),
    .pc_hold(pc_hold), .id_stall(id_stall), .if_squash(if_squash),
    .alu_a_sel(alu_a_sel), .alu_b_sel(alu_b_sel),
    .cmp_a_sel(cmp_a_sel), .cmp_b_sel(cmp_b_sel)
  );

  task automatic chk(input string req, input int got, input int exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, got, exp, $time);
    end
  endtask

  // R7 R8 R9 expected select
  function automatic int exp_sel(input logic [RW-1:0] r);
    if (r != 0 && mem_wen && !mem_load && mem_dst == r) return 2;
    if (r != 0 && wb_wen && wb_dst == r) return 1;
    return 0;
  endfunction

  function automatic bit reads(input logic [RW-1:0] d);
    return d != 0 && ((id_use_rs && id_rs == d) || (id_use_rt && id_rt == d));
  endfunction

  // R1 R2 R3 R4 expected stall
  function automatic bit exp_stall();
    bit r1_lu, r2_bex, r3_bml;
    r1_lu  = ex_wen && ex_load && reads(ex_dst);
    r2_bex = id_branch && ex_wen && reads(ex_dst);
    r3_bml = id_branch && mem_wen && mem_load && reads(mem_dst);
    return r1_lu || r2_bex || r3_bml;
  endfunction

  task automatic idle();
    {id_rs, id_rt, ex_rs, ex_rt, ex_dst, mem_dst, wb_dst} = '0;
    {id_use_rs, id_use_rt, id_branch, ex_wen, ex_load, ex_jr} = '0;
    {mem_wen, mem_load, wb_wen} = '0;
  endtask

  task automatic check_all(input string tag);
    bit s;
    @(negedge clk);
    s = exp_stall();
    chk({tag, " R1/R2/R3/R4 id_stall"}, int'(id_stall), int'(s));
    chk({tag, " R5 if_squash"}, int'(if_squash), int'(ex_jr && !s));
    chk({tag, " R6 pc_hold"}, int'(pc_hold), int'(s && !ex_jr));
    chk({tag, " R10 cmp_a_sel"}, int'(cmp_a_sel), exp_sel(id_rs));
    chk({tag, " R10 cmp_b_sel"}, int'(cmp_b_sel), exp_sel(id_rt));
    chk({tag, " R10 alu_a_sel"}, int'(alu_a_sel), exp_sel(ex_rs));
    chk({tag, " R10 alu_b_sel"}, int'(alu_b_sel), exp_sel(ex_rt));
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got 0 expected 1 (completion)");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    idle();
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // Reset/idle state: everything quiet
    @(negedge clk);
    chk("reset id_stall", int'(id_stall), 0);
    chk("reset if_squash", int'(if_squash), 0);
    chk("reset pc_hold", int'(pc_hold), 0);
    chk("reset alu_a_sel", int'(alu_a_sel), 0);

    // R2 then R3: branch right behind a load, replayed stage by stage
    @(posedge clk);
    idle();
    id_branch = 1; id_use_rs = 1; id_use_rt = 1; id_rs = 5'd7; id_rt = 5'd3;
    ex_dst = 5'd7; ex_wen = 1; ex_load = 1;
    @(negedge clk);
    chk("R2 load in EX stall cycle 1", int'(id_stall), 1);
    @(posedge clk);
    ex_dst = 0; ex_wen = 0; ex_load = 0;
    mem_dst = 5'd7; mem_wen = 1; mem_load = 1;
    @(negedge clk);
    chk("R3 load in MEM stall cycle 2", int'(id_stall), 1);
    chk("R8 load in MEM not forwarded", int'(cmp_a_sel), 0);
    @(posedge clk);
    mem_dst = 0; mem_wen = 0; mem_load = 0;
    wb_dst = 5'd7; wb_wen = 1;
    @(negedge clk);
    chk("R3 released in cycle 3", int'(id_stall), 0);
    chk("R10 branch takes write-back value", int'(cmp_a_sel), 1);

    // R4: ALU consumer of an ALU result does not stall, it forwards
    @(posedge clk);
    idle();
    id_use_rs = 1; id_rs = 5'd9; ex_dst = 5'd9; ex_wen = 1;
    @(negedge clk);
    chk("R4 ALU-ALU no stall", int'(id_stall), 0);

    // R10: jump-and-link in MEM feeds register jump target in EX
    @(posedge clk);
    idle();
    ex_jr = 1; ex_rs = 5'd31; mem_dst = 5'd31; mem_wen = 1;
    wb_dst = 5'd31; wb_wen = 1;
    @(negedge clk);
    chk("R10 link picked from MEM", int'(alu_a_sel), 2);
    chk("R5 register jump squashes fetch", int'(if_squash), 1);

    // R9: register zero never stalls or forwards
    @(posedge clk);
    idle();
    id_branch = 1; id_use_rs = 1; ex_wen = 1; ex_load = 1; mem_wen = 1; wb_wen = 1;
    @(negedge clk);
    chk("R9 zero no stall", int'(id_stall), 0);
    chk("R9 zero no forward", int'(cmp_a_sel), 0);

    // R5/R6: stall collides with register jump in EX
    @(posedge clk);
    idle();
    ex_jr = 1; id_branch = 1; id_use_rt = 1; id_rt = 5'd4;
    mem_dst = 5'd4; mem_wen = 1; mem_load = 1;
    @(negedge clk);
    chk("R5 stall suppresses squash", int'(if_squash), 0);
    chk("R6 redirect beats hold", int'(pc_hold), 0);
    chk("R1/R3 stall present", int'(id_stall), 1);

    // R1 on rt only, with rs unused
    @(posedge clk);
    idle();
    id_use_rt = 1; id_rt = 5'd2; id_rs = 5'd2; ex_dst = 5'd2; ex_wen = 1; ex_load = 1;
    @(negedge clk);
    chk("R1 load-use on rt", int'(id_stall), 1);

    // Random mix, small register range to make matches common
    for (int i = 0; i < 4000; i++) begin
      @(posedge clk);
      id_rs = RW'($urandom % 4); id_rt = RW'($urandom % 4);
      ex_rs = RW'($urandom % 4); ex_rt = RW'($urandom % 4);
      ex_dst = RW'($urandom % 4); mem_dst = RW'($urandom % 4);
      wb_dst = RW'($urandom % 4);
      id_use_rs = 1'($urandom); id_use_rt = 1'($urandom);
      id_branch = 1'($urandom); ex_wen = 1'($urandom);
      ex_load = 1'($urandom); ex_jr = ($urandom % 4) == 0;
      mem_wen = 1'($urandom); mem_load = 1'($urandom); wb_wen = 1'($urandom);
      check_all("rand");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule